// File: doc/BRIEF.md
# Completion Interrupt Pacer with Pointer-Match Acknowledge

This block collects completion events from a set of DMA queues and turns them into one paced interrupt line. The queues are split into a receive group and a transmit group. Each time the DMA engine records a completion pointer for a queue, the block stores that pointer and raises the queue's pending bit in a status vector. Software acknowledges a queue by writing a completion pointer back. The pending bit clears only if the written value equals the pointer the hardware last stored for that queue. A stale or wrong value leaves the bit set, so no completion can be lost between the moment software reads its queue and the moment it acknowledges.

The physical interrupt is held back by a countdown timer. The timer counts down on an external prescale strobe. Software programs its reload value, and every matching acknowledge restarts it from that value. Pending bits are therefore gathered for a programmable time before the CPU is interrupted. A reload value of zero removes the delay.

Top module: `cmpl_irq_pacer`

## Requirements
- R1: A hardware completion write (`hw_cp_wr` high) sets bit `hw_cp_qid` of `irq_status` on the next clock edge and stores `hw_cp_ptr` as that queue's pointer. Receive queues use indices 0 to NUM_RX-1 and transmit queues use indices NUM_RX to NUM_RX+NUM_TX-1.
- R2: A CPU acknowledge (`cpu_ack_wr` high) whose `cpu_ack_ptr` equals the stored pointer of queue `cpu_ack_qid` clears that queue's pending bit on the next edge.
- R3: An acknowledge whose value differs from the stored pointer leaves the pending bit set. An acknowledge never changes the bit of any other queue.
- R4: When a hardware write and a matching acknowledge reach the same queue in one cycle, the bit stays set and the new hardware pointer replaces the old one.
- R5: `irq_out` is high exactly when at least one status bit is set and the pacing countdown is at zero.
- R6: The countdown decreases by one on each cycle with `pace_tick` high and stays at zero once it gets there.
- R7: An acknowledge that matches its queue's stored pointer reloads the countdown from the reload register. An acknowledge that does not match leaves the countdown unchanged.
- R8: A write on `cpu_pace_wr` stores `cpu_pace_val` as the reload value and loads it into the countdown at once. This write takes priority over a reload from an acknowledge. A value of 0 means the interrupt is not delayed.
- R9: `irq_out` is low in the cycle after the acknowledge that clears the last set status bit.
- R10: After reset, every status bit and every stored pointer is zero, and both the reload value and the countdown equal RST_PACE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_cp_wr | input | 1 | Hardware completion pointer write strobe |
| hw_cp_qid | input | QID_W | Queue index of the hardware write |
| hw_cp_ptr | input | PTR_W | Completion pointer written by hardware |
| cpu_ack_wr | input | 1 | CPU acknowledge write strobe |
| cpu_ack_qid | input | QID_W | Queue index of the acknowledge |
| cpu_ack_ptr | input | PTR_W | Pointer value written by the CPU |
| cpu_pace_wr | input | 1 | Write strobe for the pacing reload value |
| cpu_pace_val | input | PACE_W | New pacing reload value |
| pace_tick | input | 1 | Prescale strobe that decrements the countdown |
| irq_status | output | NUM_RX+NUM_TX | Per-queue pending bits |
| irq_out | output | 1 | Paced interrupt line |

## Verification
The hardest cases to reach are the collision, where a new hardware completion and a matching acknowledge hit one queue in the same cycle, and the proof that a restart of the countdown really happened. The bench drives both strobes together and then acknowledges with the old pointer and the new pointer in turn. It shows the restart by counting prescale ticks after a matching acknowledge and a fresh completion. It also sweeps every pointer and acknowledge value pair on every queue of a four-queue build, while the other queues are held pending so that any disturbance of a neighbour shows up.

// File: rtl/cip_pkg.sv
package cip_pkg;
   typedef enum logic [0:0] {QK_RX = 1'b0, QK_TX = 1'b1} qkind_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic qkind_e kind_of(input int unsigned idx, input int unsigned n_rx);
      return (idx < n_rx) ? QK_RX : QK_TX;
   endfunction
endpackage

// File: rtl/cip_queue_cell.sv
module cip_queue_cell #(
   parameter int unsigned PTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_set,
   input  logic [PTR_W-1:0] hw_ptr,
   input  logic             ack_wr,
   input  logic [PTR_W-1:0] ack_ptr,
   output logic             pending,
   output logic             ack_match
);
   logic [PTR_W-1:0] last_ptr;

   assign ack_match = ack_wr && (ack_ptr == last_ptr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending  <= 1'b0;
         last_ptr <= '0;
      end else if (hw_set) begin
         pending  <= 1'b1;
         last_ptr <= hw_ptr;
      end else if (ack_match) begin
         pending  <= 1'b0;
      end
   end

   // R1
   hw_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> pending);
   // R2
   match_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_match && !hw_set) |=> !pending);
   // R3
   mismatch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !ack_match) |=> pending);
   // R4
   collision_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set && ack_match) |=> (pending && last_ptr == $past(hw_ptr)));
endmodule

// File: rtl/cip_pace_timer.sv
module cip_pace_timer #(
   parameter int unsigned PACE_W   = 16,
   parameter int unsigned RST_PACE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pace_wr,
   input  logic [PACE_W-1:0] pace_val,
   input  logic              service,
   input  logic              tick,
   output logic              expired
);
   localparam logic [PACE_W-1:0] RST_VAL = PACE_W'(RST_PACE);

   logic [PACE_W-1:0] reload_q;
   logic [PACE_W-1:0] cnt_q;

   assign expired = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= RST_VAL;
         cnt_q    <= RST_VAL;
      end else if (pace_wr) begin
         reload_q <= pace_val;
         cnt_q    <= pace_val;
      end else if (service) begin
         cnt_q    <= reload_q;
      end else if (tick && cnt_q != '0) begin
         cnt_q    <= cnt_q - 1'b1;
      end
   end

   // R6
   tick_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !expired && !pace_wr && !service) |=> (cnt_q == $past(cnt_q) - 1'b1));
   // R6
   saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !pace_wr && !service) |=> expired);
   // R7
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (service && !pace_wr) |=> (cnt_q == $past(reload_q)));
   // R8
   pace_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pace_wr |=> (cnt_q == $past(pace_val) && reload_q == $past(pace_val)));
endmodule

// File: rtl/cmpl_irq_pacer.sv
module cmpl_irq_pacer #(
   parameter int unsigned NUM_RX   = 16,
   parameter int unsigned NUM_TX   = 16,
   parameter int unsigned PTR_W    = 32,
   parameter int unsigned PACE_W   = 16,
   parameter int unsigned RST_PACE = 0,
   localparam int unsigned NQ      = NUM_RX + NUM_TX,
   localparam int unsigned QID_W   = cip_pkg::idx_width(NQ)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_cp_wr,
   input  logic [QID_W-1:0]  hw_cp_qid,
   input  logic [PTR_W-1:0]  hw_cp_ptr,
   input  logic              cpu_ack_wr,
   input  logic [QID_W-1:0]  cpu_ack_qid,
   input  logic [PTR_W-1:0]  cpu_ack_ptr,
   input  logic              cpu_pace_wr,
   input  logic [PACE_W-1:0] cpu_pace_val,
   input  logic              pace_tick,
   output logic [NQ-1:0]     irq_status,
   output logic              irq_out
);
   import cip_pkg::*;

   if (NQ < 1 || NQ > 32) begin : g_bad_nq
      $error("cmpl_irq_pacer: queue count must be 1..32");
   end
   if (PTR_W < 1) begin : g_bad_ptr
      $error("cmpl_irq_pacer: PTR_W must be at least 1");
   end
   if (PACE_W < 1 || PACE_W > 31) begin : g_bad_pace
      $error("cmpl_irq_pacer: PACE_W must be 1..31");
   end
   if (RST_PACE >= (1 << PACE_W)) begin : g_bad_rst
      $error("cmpl_irq_pacer: RST_PACE does not fit PACE_W");
   end

   logic [NQ-1:0] match_vec;
   logic          service;
   logic          expired;
   logic          any_pend;

   for (genvar gq = 0; gq < NQ; gq++) begin : g_q
      localparam qkind_e KIND = kind_of(gq, NUM_RX);
      logic set_q;
      logic ack_q;
      assign set_q = hw_cp_wr   && (hw_cp_qid   == QID_W'(gq));
      assign ack_q = cpu_ack_wr && (cpu_ack_qid == QID_W'(gq));

      cip_queue_cell #(.PTR_W(PTR_W)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .hw_set    (set_q),
         .hw_ptr    (hw_cp_ptr),
         .ack_wr    (ack_q),
         .ack_ptr   (cpu_ack_ptr),
         .pending   (irq_status[gq]),
         .ack_match (match_vec[gq])
      );
   end

   assign service  = |match_vec;
   assign any_pend = |irq_status;

   cip_pace_timer #(.PACE_W(PACE_W), .RST_PACE(RST_PACE)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .pace_wr  (cpu_pace_wr),
      .pace_val (cpu_pace_val),
      .service  (service),
      .tick     (pace_tick),
      .expired  (expired)
   );

   assign irq_out = any_pend && expired;

   // R9
   last_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack_wr && !hw_cp_wr && service && $countones(irq_status) == 1
       && irq_status[cpu_ack_qid]) |=> !irq_out);
   // R7
   ack_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (service && !cpu_pace_wr && any_pend && !expired) |=> !irq_out || $past(hw_cp_wr) == 1'b0);
   // R3
   ack_only_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));
endmodule

// File: tb/cmpl_irq_pacer_tb.sv
module cmpl_irq_pacer_tb;
   localparam int NRX = 2, NTX = 2, PW = 4, CW = 3, NQ = NRX + NTX;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hw_cp_wr = 0, cpu_ack_wr = 0, cpu_pace_wr = 0, pace_tick = 0;
   logic [1:0] hw_cp_qid = 0, cpu_ack_qid = 0;
   logic [PW-1:0] hw_cp_ptr = 0, cpu_ack_ptr = 0;
   logic [CW-1:0] cpu_pace_val = 0;
   logic [NQ-1:0] irq_status;
   logic irq_out;

   int checks = 0, errors = 0, cycles = 0;
   logic [NQ-1:0] exp_st = '0;

   always #5 clk = ~clk;

   cmpl_irq_pacer #(.NUM_RX(NRX), .NUM_TX(NTX), .PTR_W(PW), .PACE_W(CW), .RST_PACE(0)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .hw_cp_wr(hw_cp_wr), .hw_cp_qid(hw_cp_qid), .hw_cp_ptr(hw_cp_ptr),
      .cpu_ack_wr(cpu_ack_wr), .cpu_ack_qid(cpu_ack_qid), .cpu_ack_ptr(cpu_ack_ptr),
      .cpu_pace_wr(cpu_pace_wr), .cpu_pace_val(cpu_pace_val), .pace_tick(pace_tick),
      .irq_status(irq_status), .irq_out(irq_out));

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: act=hung exp=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic hw(input int q, input int p);
      hw_cp_wr = 1; hw_cp_qid = 2'(q); hw_cp_ptr = PW'(p);
      @(negedge clk); hw_cp_wr = 0;
      exp_st[q] = 1'b1;
   endtask

   task automatic ack(input int q, input int p);
      cpu_ack_wr = 1; cpu_ack_qid = 2'(q); cpu_ack_ptr = PW'(p);
      @(negedge clk); cpu_ack_wr = 0;
   endtask

   task automatic pace(input int r);
      cpu_pace_wr = 1; cpu_pace_val = CW'(r);
      @(negedge clk); cpu_pace_wr = 0;
   endtask

   task automatic tick();
      pace_tick = 1; @(negedge clk); pace_tick = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10 status", int'(irq_status), 0);
      chk("R10 irq", int'(irq_out), 0);
      // R10: stored pointers are zero, so acking 0 on an idle queue changes nothing visible
      ack(1, 0);
      chk("R10 ack0", int'(irq_status), 0);

      // R1 R2 R3 R5 R9: exhaustive pointer/ack sweep, reload 0
      for (int q = 0; q < NQ; q++) begin
         for (int o = 0; o < NQ; o++) if (o != q) hw(o, 5 + o);
         for (int p = 0; p < 16; p++) begin
            for (int a = 0; a < 16; a++) begin
               hw(q, p);
               chk("R1 set", int'(irq_status), int'(exp_st));
               chk("R5 irq", int'(irq_out), 1);
               ack(q, a);
               if (a == p) exp_st[q] = 1'b0;
               chk(a == p ? "R2 clear" : "R3 hold", int'(irq_status), int'(exp_st));
               if (a != p) begin
                  ack(q, p); exp_st[q] = 1'b0;
                  chk("R2 clear2", int'(irq_status), int'(exp_st));
               end
            end
         end
         for (int o = 0; o < NQ; o++) if (o != q) begin
            ack(o, 5 + o); exp_st[o] = 1'b0;
         end
         chk("R9 status", int'(irq_status), 0);
         chk("R9 irq", int'(irq_out), 0);
      end

      // R6 R7 R8: pacing sweep over every reload value
      for (int r = 0; r < 8; r++) begin
         pace(r);
         hw(0, 3);
         for (int k = 0; k <= r + 1; k++) begin
            chk("R6 count", int'(irq_out), (k >= r) ? 1 : 0);
            tick();
         end
         chk("R6 saturate", int'(irq_out), 1);
         ack(0, 3); exp_st[0] = 0;
         chk("R9 drop", int'(irq_out), 0);
         hw(1, 9);
         for (int k = 0; k <= r; k++) begin
            chk("R7 reload", int'(irq_out), (k >= r) ? 1 : 0);
            tick();
         end
         ack(1, 9); exp_st[1] = 0;
      end

      // R7: mismatching ack does not restart the countdown
      pace(3);
      hw(0, 1);
      tick(); tick(); tick();
      chk("R7 expired", int'(irq_out), 1);
      ack(0, 2);
      chk("R7 no reload", int'(irq_out), 1);
      ack(0, 1); exp_st[0] = 0;

      // R8: reload write wins over a same-cycle matching ack
      hw(3, 6);
      cpu_pace_wr = 1; cpu_pace_val = 3'd0;
      cpu_ack_wr = 1; cpu_ack_qid = 2'd3; cpu_ack_ptr = 4'd6;
      @(negedge clk); cpu_pace_wr = 0; cpu_ack_wr = 0; exp_st[3] = 0;
      hw(2, 8);
      chk("R8 priority", int'(irq_out), 1);
      ack(2, 8); exp_st[2] = 0;

      // R4: collision of hw write and matching ack
      pace(0);
      hw(2, 4);
      hw_cp_wr = 1; hw_cp_qid = 2'd2; hw_cp_ptr = 4'd7;
      cpu_ack_wr = 1; cpu_ack_qid = 2'd2; cpu_ack_ptr = 4'd4;
      @(negedge clk); hw_cp_wr = 0; cpu_ack_wr = 0;
      chk("R4 stays", int'(irq_status[2]), 1);
      ack(2, 4);
      chk("R4 old ptr", int'(irq_status[2]), 1);
      ack(2, 7);
      chk("R4 new ptr", int'(irq_status[2]), 0);
      chk("R9 final", int'(irq_out), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule